// File: doc/BRIEF.md
# Serial Audio Transmit Channel Buffer

This block drives one outgoing serial audio channel. A 32-bit shift register sends its contents most significant bit first, one bit for each bit-clock cycle in which the time-slot strobe is high. Two parallel write registers feed the shift register, one owned by a signal processor and one by a host. A select bit chooses which of the two supplies the next word.

The shift register is refilled in one of two ways. In count mode, it is refilled after a programmed number of bits has left the channel. In frame mode, it is refilled at every frame sync pulse. In frame mode the slot length alone decides how many bits reach the line. Each refill raises sticky status flags that the writer can mask or clear, and these flags drive a single interrupt line. If a refill happens and the selected register has not been written since its last use, the old word is sent again and an underrun flag is raised.

Top module: `tx_audio_chan`

## Requirements
- R1: After reset: the shift register, bit count, both write registers, their written-since-use marks and all status bits are zero. `sdo` and `irq` are low.
- R2: In a cycle where `en` and `slot` are both high, `sdo` equals the shift register's top bit. At that edge the register shifts left by one with a zero entering at the bottom, unless a refill happens. Outside such cycles `sdo` is 0.
- R3: A refill copies the DSP write register when `src_host`=0 and the host write register when `src_host`=1. `src_host` is sampled in the refill cycle.
- R4: Count mode (`mode_frame`=0): the block counts slot cycles since the last refill. A refill happens at the edge of the slot cycle that brings the count to T, and the count then restarts at zero. T equals `lbit` for 1..DW; `lbit`=0 or `lbit`>DW gives T=DW. In frame mode the count is held at zero.
- R5: Frame mode (`mode_frame`=1): a refill happens at the edge of every enabled cycle with `fs` high, and takes priority over a shift in the same cycle. `fs` causes no refill in count mode.
- R6: `status[0]` (empty) is set by every count-mode refill.
- R7: `status[1]` (frame) is set by every enabled cycle with `fs` high, in either mode.
- R8: `status[2]` (underrun) is set by a refill when the selected register has not been written since its last refill or since reset. The old word is sent again. A write in the refill cycle stores the new data for the next refill, and the refill still takes the old word.
- R9: Status bits stay set until `st_clr` has a one at their position. A set in the same cycle as a clear wins.
- R10: `irq` is high exactly when some status bit is set with a one at the same position of `st_mask`.
- R11: While `en` is low there is no shifting, refill, count change or status setting, and `sdo` is 0. Register writes and clears still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Channel enable |
| mode_frame | input | 1 | 1: refill at frame sync; 0: refill after T bits |
| src_host | input | 1 | 1: host register feeds refills; 0: DSP register |
| lbit | input | CW | Bit threshold for count mode |
| fs | input | 1 | Transmit frame sync pulse |
| slot | input | 1 | Time-slot strobe, one bit per high cycle |
| dsp_wr | input | 1 | DSP register write strobe |
| dsp_wdata | input | DW | DSP register write data |
| host_wr | input | 1 | Host register write strobe |
| host_wdata | input | DW | Host register write data |
| st_clr | input | 3 | Write-one-to-clear pulses for status |
| st_mask | input | 3 | Interrupt enable per status bit |
| sdo | output | 1 | Serial data out |
| status | output | 3 | {underrun, frame, empty} sticky flags |
| irq | output | 1 | Masked OR of status |

## Verification
The assertions check the following properties on every cycle:
- Shifting, held state while disabled, and status stability while disabled.
- The refill timing rules per mode: slot-bound refills in count mode, and refills that follow `fs` in frame mode.
- Flag setting after each event, and flag stickiness.
- The bit count bound.

Only the bench scenarios can show that the correct word is sent. This covers which source is chosen, the exact T for each `lbit` including 0 and out-of-range values, and repeated words on underrun. The bench sweeps every `lbit` value and every mask value on an 8-bit configuration, with gapped slots and short frame slots, and compares each output bit against arithmetic expectations.

// File: rtl/tx_chan_pkg.sv
package tx_chan_pkg;
  localparam int ST_EMPTY = 0;
  localparam int ST_FRAME = 1;
  localparam int ST_UNDER = 2;
  localparam int ST_W     = 3;

  typedef enum logic {SRC_DSP = 1'b0, SRC_HOST = 1'b1} src_e;

  // effective bit threshold: zero or over-range selects the full width
  function automatic int unsigned eff_thr(int unsigned lbit, int unsigned dw);
    if (lbit == 0 || lbit > dw) return dw;
    return lbit;
  endfunction
endpackage

// File: rtl/txc_wreg.sv
module txc_wreg #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          take,
  output logic [DW-1:0] q,
  output logic          fresh
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q     <= '0;
      fresh <= 1'b0;
    end else begin
      if (wr) q <= wdata;
      if (wr)        fresh <= 1'b1;
      else if (take) fresh <= 1'b0;
    end
  end
endmodule

// File: rtl/txc_shifter.sv
module txc_shifter
  import tx_chan_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = $clog2(DW) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          mode_frame,
  input  logic          slot,
  input  logic          fs,
  input  logic [CW-1:0] lbit,
  input  logic [DW-1:0] load_data,
  output logic          reload,
  output logic          sdo,
  output logic [DW-1:0] sr_q,
  output logic [CW-1:0] cnt_q
);
  logic [CW-1:0] thr;
  logic          last_bit;
  logic          shift_ev;

  assign thr      = CW'(eff_thr(int'(lbit), DW));
  assign last_bit = (cnt_q + CW'(1)) >= thr;
  assign reload   = en & (mode_frame ? fs : (slot & last_bit));
  assign shift_ev = en & slot & ~reload;
  assign sdo      = en & slot & sr_q[DW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (reload)        sr_q <= load_data;
      else if (shift_ev) sr_q <= {sr_q[DW-2:0], 1'b0};

      if (mode_frame || reload) cnt_q <= '0;
      else if (shift_ev)        cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/txc_status.sv
module txc_status
  import tx_chan_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ST_W-1:0] set,
  input  logic [ST_W-1:0] clr,
  input  logic [ST_W-1:0] mask,
  output logic [ST_W-1:0] st_q,
  output logic            irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= (st_q & ~clr) | set;
  end

  assign irq = |(st_q & mask);
endmodule

// File: rtl/tx_audio_chan.sv
module tx_audio_chan
  import tx_chan_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = $clog2(DW) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          mode_frame,
  input  logic          src_host,
  input  logic [CW-1:0] lbit,
  input  logic          fs,
  input  logic          slot,
  input  logic          dsp_wr,
  input  logic [DW-1:0] dsp_wdata,
  input  logic          host_wr,
  input  logic [DW-1:0] host_wdata,
  input  logic [2:0]    st_clr,
  input  logic [2:0]    st_mask,
  output logic          sdo,
  output logic [2:0]    status,
  output logic          irq
);
  localparam int NSRC = 2;

  logic [NSRC-1:0]         wr_v;
  logic [NSRC-1:0][DW-1:0] wd_v;
  logic [NSRC-1:0][DW-1:0] q_v;
  logic [NSRC-1:0]         fresh_v;
  logic [NSRC-1:0]         take_v;

  // named internal events for the checker
  logic          reload_ev;
  logic          sel_fresh;
  logic          under_ev;
  logic          fs_ev;
  logic [DW-1:0] sel_data;
  logic [DW-1:0] sr_q;
  logic [CW-1:0] cnt_q;
  logic [ST_W-1:0] st_set;
  src_e          src;

  assign src     = src_e'(src_host);
  assign wr_v    = {host_wr, dsp_wr};
  assign wd_v[0] = dsp_wdata;
  assign wd_v[1] = host_wdata;

  genvar gi;
  generate
    for (gi = 0; gi < NSRC; gi++) begin : g_src
      assign take_v[gi] = reload_ev & (int'(src) == gi);
      txc_wreg #(.DW(DW)) u_wreg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr_v[gi]),
        .wdata (wd_v[gi]),
        .take  (take_v[gi]),
        .q     (q_v[gi]),
        .fresh (fresh_v[gi])
      );
    end
  endgenerate

  assign sel_data  = (src == SRC_HOST) ? q_v[1] : q_v[0];
  assign sel_fresh = (src == SRC_HOST) ? fresh_v[1] : fresh_v[0];

  txc_shifter #(.DW(DW), .CW(CW)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .mode_frame (mode_frame),
    .slot       (slot),
    .fs         (fs),
    .lbit       (lbit),
    .load_data  (sel_data),
    .reload     (reload_ev),
    .sdo        (sdo),
    .sr_q       (sr_q),
    .cnt_q      (cnt_q)
  );

  assign under_ev         = reload_ev & ~sel_fresh;
  assign fs_ev            = en & fs;
  assign st_set[ST_EMPTY] = reload_ev & ~mode_frame;
  assign st_set[ST_FRAME] = fs_ev;
  assign st_set[ST_UNDER] = under_ev;

  txc_status u_stat (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (st_set),
    .clr   (st_clr),
    .mask  (st_mask),
    .st_q  (status),
    .irq   (irq)
  );
endmodule

// File: rtl/tx_audio_chan_chk.sv
module tx_audio_chan_chk #(
  parameter int DW = 32,
  parameter int CW = $clog2(DW) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          mode_frame,
  input logic          fs,
  input logic          slot,
  input logic [2:0]    st_clr,
  input logic [2:0]    status,
  input logic          irq,
  input logic          sdo,
  input logic          reload_ev,
  input logic          sel_fresh,
  input logic [DW-1:0] sr_q,
  input logic [CW-1:0] cnt_q
);
  a_r2_shift: assert property (@(posedge clk) disable iff (!rst_n)
    en && slot && !reload_ev |=> sr_q == {$past(sr_q[DW-2:0]), 1'b0});
  a_r2_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !slot |-> !sdo);
  a_r4_slot_only: assert property (@(posedge clk) disable iff (!rst_n)
    en && !mode_frame && reload_ev |-> slot);
  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(DW));
  a_r5_fs_reload: assert property (@(posedge clk) disable iff (!rst_n)
    en && mode_frame |-> reload_ev == fs);
  a_r6_empty_set: assert property (@(posedge clk) disable iff (!rst_n)
    en && !mode_frame && reload_ev |=> status[0]);
  a_r7_frame_set: assert property (@(posedge clk) disable iff (!rst_n)
    en && fs |=> status[1]);
  a_r8_under_set: assert property (@(posedge clk) disable iff (!rst_n)
    reload_ev && !sel_fresh |=> status[2]);
  a_r9_sticky0: assert property (@(posedge clk) disable iff (!rst_n)
    status[0] && !st_clr[0] |=> status[0]);
  a_r9_sticky1: assert property (@(posedge clk) disable iff (!rst_n)
    status[1] && !st_clr[1] |=> status[1]);
  a_r9_sticky2: assert property (@(posedge clk) disable iff (!rst_n)
    status[2] && !st_clr[2] |=> status[2]);
  a_r10_irq_src: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> status != 3'b000);
  a_r11_hold_sr: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(sr_q));
  a_r11_hold_st: assert property (@(posedge clk) disable iff (!rst_n)
    !en && st_clr == 3'b000 |=> $stable(status));
endmodule

bind tx_audio_chan tx_audio_chan_chk #(.DW(DW), .CW(CW)) u_chk (.*);

// File: tb/sim_tx_audio_chan.sv
module sim_tx_audio_chan;
  localparam int DW = 8;
  localparam int CW = $clog2(DW) + 1;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 0, mode_frame = 0, src_host = 0, fs = 0, slot = 0;
  logic dsp_wr = 0, host_wr = 0;
  logic [CW-1:0] lbit = '0;
  logic [DW-1:0] dsp_wdata = '0, host_wdata = '0;
  logic [2:0] st_clr = '0, st_mask = '0;
  logic sdo, irq;
  logic [2:0] status;

  int total = 0, bad = 0;
  logic done = 1'b0;

  // bench-side expectations
  logic [DW-1:0] m_sr = '0, m_dsp = '0, m_host = '0;
  int            m_cnt = 0;
  logic          m_fd = 0, m_fh = 0;
  logic [2:0]    m_st = '0;
  logic [15:0]   r = 16'hACE1;

  always #(CLK_P/2) clk = ~clk;

  tx_audio_chan #(.DW(DW), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .mode_frame(mode_frame),
    .src_host(src_host), .lbit(lbit), .fs(fs), .slot(slot),
    .dsp_wr(dsp_wr), .dsp_wdata(dsp_wdata), .host_wr(host_wr),
    .host_wdata(host_wdata), .st_clr(st_clr), .st_mask(st_mask),
    .sdo(sdo), .status(status), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // inputs are set; sample mid-cycle, then advance the expectations
  task automatic cyc(input string tag);
    int  t;
    logic rel, fr;
    #(CLK_P/2);
    chk({tag, " sdo"}, int'(sdo), int'(en && slot && m_sr[DW-1]));
    chk({tag, " status"}, int'(status), int'(m_st));
    chk({tag, " R10 irq"}, int'(irq), int'(|(m_st & st_mask)));
    t   = (lbit == 0 || int'(lbit) > DW) ? DW : int'(lbit);
    rel = en && (mode_frame ? fs : (slot && (m_cnt + 1 >= t)));
    fr  = src_host ? m_fh : m_fd;
    m_st = (m_st & ~st_clr) | {rel && !fr, en && fs, rel && !mode_frame};
    if (rel) m_sr = src_host ? m_host : m_dsp;
    else if (en && slot) m_sr = m_sr << 1;
    if (mode_frame || rel) m_cnt = 0;
    else if (en && slot) m_cnt = m_cnt + 1;
    if (dsp_wr) m_fd = 1; else if (rel && !src_host) m_fd = 0;
    if (host_wr) m_fh = 1; else if (rel && src_host) m_fh = 0;
    if (dsp_wr) m_dsp = dsp_wdata;
    if (host_wr) m_host = host_wdata;
    r = {r[14:0], r[15] ^ r[13] ^ r[12] ^ r[10]};
    @(posedge clk); #1;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset sdo", int'(sdo), 0);
    chk("R1 reset status", int'(status), 0);
    chk("R1 reset irq", int'(irq), 0);
    rst_n = 1'b1;
    en = 1; slot = 1; st_mask = 3'b111;
    cyc("R1 first cycle");

    // R4 R6: every lbit value, continuous slot, DSP source
    for (int lb = 0; lb < (1 << CW); lb++) begin
      lbit = CW'(lb);
      for (int i = 0; i < 3 * DW; i++) begin
        dsp_wr = !m_fd; dsp_wdata = r[DW-1:0];
        st_clr = (i % 5 == 0) ? 3'b111 : 3'b000;
        st_mask = 3'b001;
        cyc("R4 R6 sweep");
      end
    end

    for (int s = 1; s < 8; s++) begin
      for (int i = 0; i < 300; i++) begin
        en = 1; mode_frame = 0; src_host = 0; fs = 0; slot = 1;
        dsp_wr = !m_fd; host_wr = !m_fh;
        dsp_wdata = r[DW-1:0]; host_wdata = r[15:16-DW];
        st_clr = 3'b000; st_mask = 3'b111; lbit = CW'(DW);
        case (s)
          1: begin slot = r[0] | r[1]; lbit = CW'(5);
             cyc("R2 gapped slots"); end
          2: begin src_host = r[2]; dsp_wr = r[3]; host_wr = r[4];
             cyc("R3 source select"); end
          3: begin mode_frame = 1; fs = (i % 10 == 0); slot = (i % 10) < 6;
             st_clr = {1'b0, (i % 10 == 5), 1'b0};
             cyc("R5 R7 frame mode"); end
          4: begin dsp_wr = 0; host_wr = (i % 37 == 0); src_host = r[2];
             mode_frame = (i >= 150); fs = (i % 9 == 0); lbit = CW'(3);
             cyc("R8 underrun"); end
          5: begin st_clr = r[7:5]; st_mask = r[10:8]; fs = r[11] & r[12];
             dsp_wr = r[3]; lbit = CW'(2);
             cyc("R9 R10 clear and mask"); end
          6: begin en = (i < 10) || (i % 50 > 40); slot = r[0]; fs = r[1];
             dsp_wr = r[3]; host_wr = r[4]; src_host = r[2];
             mode_frame = r[5]; st_clr = (i % 60 == 59) ? 3'b111 : 3'b000;
             cyc("R11 disabled"); end
          default: begin en = r[13] | r[14]; mode_frame = r[5] & r[6];
             slot = r[0] | r[7]; fs = r[1] & r[8]; src_host = r[2];
             dsp_wr = r[3]; host_wr = r[4]; lbit = r[CW-1:0];
             st_clr = r[11:9] & {3{r[12]}}; st_mask = r[10:8];
             cyc("R2 R3 R4 R5 mixed"); end
        endcase
      end
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule